// File: doc/BRIEF.md
# Decode-Stage Branch-If-Equal Resolver

This block settles a branch-if-equal instruction while it sits in the decode stage of a five-stage pipeline that fetches as if no branch is taken. It takes the two operand values the register file has just read, a flag that marks the decoded instruction as a branch-if-equal, the already-incremented address of that branch and its 16-bit immediate. A bit-parallel equality comparator decides the branch, and a dedicated adder forms the target address. The adder does not wait for the comparator.

When the branch is taken, the block asks for two things in the same cycle. The fetch address register must load the target instead of advancing by four. The instruction now being fetched must be killed, so that the fetch/decode pipeline register receives the all-zero word, which is a shift of register zero by zero and has no effect. A taken branch therefore costs one bubble and no more. A branch that falls through costs nothing. The block has no storage of its own. The fetch address register and the fetch/decode register belong to the surrounding pipeline. The decision is a two-state choice: FALL_THRU, where the address advances sequentially, and TAKE, where the pipeline redirects and flushes. It moves FALL_THRU→TAKE only when the branch flag is set and the operands match, and returns TAKE→FALL_THRU when either condition drops.

Top module: `id_branch_resolve`

## Requirements
- R1: With no taken branch in decode, `redirect_o` is 0, so the fetch address advances by 4 each cycle and no cycles are lost.
- R2: Operands count as equal only when every one of the DATA_W bits matches. A difference in any single bit position makes them unequal.
- R3: When `is_beq_i` is 1 and the operands are equal (TAKE), `fetch_kill_o` is 1 and `redirect_o` is 1.
- R4: When `is_beq_i` is 0, `fetch_kill_o` is 0 even if the operands are equal. A branch with unequal operands also leaves `fetch_kill_o` at 0.
- R5: `redirect_o` and `fetch_kill_o` are always equal, so the fetch address loads the target in the same cycle the fetched word is killed.
- R6: `target_o` equals `pc_inc_i` plus the immediate, with the immediate sign-extended from bit 15 and shifted left by 2. The sum is modulo 2^ADDR_W, and negative immediates are included.
- R7: `target_o` is produced whatever the value of `is_beq_i` and whatever the comparison result.
- R8: In a pipeline whose fetch address resets to 0 and whose fetch/decode register resets to the all-zero word, a taken branch causes the next decode to see the all-zero word, which performs no register or memory write. The fetch after that comes from the target. A falling-through branch lets the sequential word through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a_i | input | DATA_W | First source operand read from the register file |
| op_b_i | input | DATA_W | Second source operand read from the register file |
| is_beq_i | input | 1 | Decoded instruction is a branch-if-equal |
| pc_inc_i | input | ADDR_W | Branch's own address plus 4 |
| imm_i | input | IMM_W | Branch word offset from the instruction |
| redirect_o | output | 1 | 1: next fetch address is `target_o`; 0: sequential |
| target_o | output | ADDR_W | Computed branch target address |
| fetch_kill_o | output | 1 | Replace the word being fetched with the all-zero nop |

## Verification
The bench flips each operand bit on its own, one position at a time. A comparator that skipped or mis-wired a bit would then take the branch on operands that differ. Equal operands are also presented without the branch flag, which catches a design that flushes on any equality. Offsets are swept across small negative and positive values and the two extreme immediates, on fetch addresses near zero and near the top of memory. This exposes a missing sign extension, a wrong shift amount and mishandled wraparound. A modelled pipeline then runs a mixed program of taken branches, falling-through branches and ordinary words. There, a flush and a redirect that drift apart in time would show up as a surviving wrong-path word or as a lost sequential word.

// File: rtl/br_pkg.sv
package br_pkg;

    // Outcome of the decode-stage branch decision.
    typedef enum logic [0:0] {
        FALL_THRU = 1'b0,
        TAKE      = 1'b1
    } br_state_e;

    // Word-offset scaling applied to the immediate.
    localparam int unsigned WORD_SHIFT = 2;

endpackage

// File: rtl/br_eq_cmp.sv
module br_eq_cmp #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              same_o
);
    logic [DATA_W-1:0] bit_match;

    // One match cell per bit, then a single AND reduction.
    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        assign bit_match[g] = ~(a_i[g] ^ b_i[g]);
    end

    assign same_o = &bit_match;

    always_comb begin
        p_same_means_identical_r2: assert (!same_o || (a_i == b_i))
            else $error("comparator reports equal on differing operands");
        p_identical_means_same_r2: assert (same_o || (a_i != b_i))
            else $error("comparator misses equal operands");
    end
endmodule

// File: rtl/br_target_gen.sv
module br_target_gen
    import br_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IMM_W  = 16
) (
    input  logic [ADDR_W-1:0] pc_inc_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [ADDR_W-1:0] target_o
);
    localparam int unsigned EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] imm_sext;
    logic [ADDR_W-1:0] byte_off;

    assign imm_sext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    assign byte_off = imm_sext << WORD_SHIFT;
    assign target_o = pc_inc_i + byte_off;
endmodule

// File: rtl/br_decide.sv
module br_decide
    import br_pkg::*;
(
    input  logic is_beq_i,
    input  logic same_i,
    output logic redirect_o,
    output logic kill_o
);
    br_state_e state;

    // Decision process: picks the branch outcome.
    always_comb begin
        unique case ({is_beq_i, same_i})
            2'b11:   state = TAKE;
            default: state = FALL_THRU;
        endcase
    end

    // Output process: drives the controls for each outcome.
    always_comb begin
        unique case (state)
            TAKE: begin
                redirect_o = 1'b1;
                kill_o     = 1'b1;
            end
            default: begin
                redirect_o = 1'b0;
                kill_o     = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/id_branch_resolve.sv
module id_branch_resolve
    import br_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IMM_W  = 16
) (
    input  logic [DATA_W-1:0] op_a_i,
    input  logic [DATA_W-1:0] op_b_i,
    input  logic              is_beq_i,
    input  logic [ADDR_W-1:0] pc_inc_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic              redirect_o,
    output logic [ADDR_W-1:0] target_o,
    output logic              fetch_kill_o
);
    logic ops_same;

    br_eq_cmp #(.DATA_W(DATA_W)) u_cmp (
        .a_i    (op_a_i),
        .b_i    (op_b_i),
        .same_o (ops_same)
    );

    br_target_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_tgt (
        .pc_inc_i (pc_inc_i),
        .imm_i    (imm_i),
        .target_o (target_o)
    );

    br_decide u_dec (
        .is_beq_i   (is_beq_i),
        .same_i     (ops_same),
        .redirect_o (redirect_o),
        .kill_o     (fetch_kill_o)
    );

    always_comb begin
        p_kill_with_redirect_r5: assert (redirect_o == fetch_kill_o)
            else $error("flush and redirect disagree");
        p_no_kill_without_beq_r4: assert (is_beq_i || !fetch_kill_o)
            else $error("flush raised by a non-branch");
        p_taken_when_matched_r3: assert (!(is_beq_i && (op_a_i == op_b_i)) || fetch_kill_o)
            else $error("matching branch not taken");
        p_target_sum_r6: assert (target_o ==
                ADDR_W'($signed(pc_inc_i) + ($signed(imm_i) * (2 ** WORD_SHIFT))))
            else $error("target address mismatch");
    end
endmodule

// File: tb/id_branch_resolve_tb_top.sv
module id_branch_resolve_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [31:0] op_a, op_b, pc_inc;
    logic        is_beq;
    logic [15:0] imm;
    logic        redirect, kill;
    logic [31:0] target;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    id_branch_resolve dut_i (
        .op_a_i       (op_a),
        .op_b_i       (op_b),
        .is_beq_i     (is_beq),
        .pc_inc_i     (pc_inc),
        .imm_i        (imm),
        .redirect_o   (redirect),
        .target_o     (target),
        .fetch_kill_o (kill)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bench-side pipeline: fetch address and fetch/decode register.
    logic        pipe_on = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_q, ifid_word, ifid_pcinc;

    // Program word at an address: bit31 branch, bit30 always set,
    // bit29 operands equal, low 16 bits offset.
    function automatic logic [31:0] imem(input logic [31:0] a);
        logic [31:0] idx;
        logic [15:0] off;
        idx = a >> 2;
        off = 16'(int'(idx % 5) - 2);
        return {(idx % 3) == 0, 1'b1, (idx % 4) != 1, 13'd0, off};
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q       <= 32'd0;
            ifid_word  <= 32'd0;
            ifid_pcinc <= 32'd0;
        end else if (pipe_on) begin
            pc_q       <= redirect ? target : pc_q + 32'd4;
            ifid_word  <= kill ? 32'd0 : imem(pc_q);
            ifid_pcinc <= pc_q + 32'd4;
        end
    end

    task automatic drive_from_ifid();
        is_beq = ifid_word[31];
        imm    = ifid_word[15:0];
        pc_inc = ifid_pcinc;
        op_a   = 32'hA5A5_0000 ^ ifid_pcinc;
        op_b   = ifid_word[29] ? op_a : ~op_a;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] base;
        logic [31:0] exp_pc, exp_word;
        logic        exp_take;
        op_a = 0; op_b = 0; is_beq = 0; pc_inc = 0; imm = 0;

        // Reset state of the surrounding pipeline (R8)
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R8 reset pc", pc_q, 32'd0);
        check("R8 reset ifid nop", ifid_word, 32'd0);

        // R2/R3/R4: single-bit differences and flag combinations
        base = 32'h5A3C_96F1;
        for (int b = -1; b < 32; b++) begin
            for (int f = 0; f < 2; f++) begin
                op_a   = base;
                op_b   = (b < 0) ? base : base ^ (32'd1 << b);
                is_beq = f[0];
                #1;
                exp_take = f[0] && (b < 0);
                check(b < 0 ? "R3 take on equal" : "R2 single-bit diff no flush",
                      {31'd0, kill}, {31'd0, exp_take});
                check("R5 redirect matches flush", {31'd0, redirect}, {31'd0, kill});
                if (!f[0]) check("R4 no flush without branch flag", {31'd0, kill}, 32'd0);
                if (!exp_take) check("R1 sequential select", {31'd0, redirect}, 32'd0);
            end
        end

        // R6/R7: target arithmetic sweep
        for (int p = 0; p < 4; p++) begin
            pc_inc = (p == 0) ? 32'd0 : (p == 1) ? 32'd4 :
                     (p == 2) ? 32'h0001_0000 : 32'hFFFF_FFFC;
            for (int k = -34; k < 34; k++) begin
                imm = (k == -34) ? 16'h8000 : (k == 33) ? 16'h7FFF : 16'(k);
                is_beq = k[0];
                op_a = 32'd7; op_b = k[1] ? 32'd7 : 32'd6;
                #1;
                check(k[0] ? "R6 target" : "R7 target without branch",
                      target, pc_inc + ({{16{imm[15]}}, imm} << 2));
            end
        end

        // R1/R8: run the modelled pipeline
        rst = 1'b0;
        pipe_on = 1'b1;
        drive_from_ifid();
        for (int c = 0; c < 60; c++) begin
            #1;
            exp_take = ifid_word[31] && ifid_word[29];
            exp_pc   = exp_take ? ifid_pcinc + ({{16{ifid_word[15]}}, ifid_word[15:0]} << 2)
                                : pc_q + 32'd4;
            exp_word = exp_take ? 32'd0 : imem(pc_q);
            @(posedge clk);
            @(negedge clk);
            check(exp_take ? "R8 next fetch from target" : "R1 advance by 4", pc_q, exp_pc);
            check(exp_take ? "R8 flushed slot is nop" : "R1 word passes", ifid_word, exp_word);
            drive_from_ifid();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule